// File: doc/BRIEF.md
# I2C Register-File Target with Auto-Incrementing Pointer

This block is a bus target on a two-wire serial bus. It sits on a system clock at least sixteen times faster than the serial clock and watches both lines through a synchronizer. A start condition arms it to receive an address byte. If the seven address bits match the `DEV_ADDR` parameter, it acknowledges. The eighth bit then picks the direction: writes from the controller, or reads by the controller. All other addresses are ignored until the next start.

In write direction, the first data byte does not land in storage; it sets an internal register pointer. Every later byte is stored at the pointer, which then advances by one and wraps from the last register to zero. In read direction, bytes come out of the register at the pointer, most significant bit first, and the pointer again advances after each byte. The pointer survives a repeated start, so a controller can write a pointer, issue a repeated start with the read bit set, and receive data from the chosen register onward. The data line is driven only low, through `sda_drive_low`; the pull-up and the wired-AND live outside.

The controller is a single state machine. Its states are ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WRITE, ST_WRITE_ACK, ST_READ, ST_READ_ACK and ST_IGNORE. Its transitions are:
- Start, from any state, leads to ST_ADDR.
- Stop, from any state, leads to ST_IDLE.
- From ST_ADDR, at the falling clock after eight bits: to ST_ADDR_ACK on an address match, otherwise to ST_IGNORE.
- From ST_ADDR_ACK, at the next falling clock: to ST_READ or ST_WRITE, according to the direction bit.
- ST_WRITE and ST_WRITE_ACK alternate, one byte and one acknowledge at a time.
- ST_READ leads to ST_READ_ACK. From ST_READ_ACK the machine returns to ST_READ when the controller acknowledged, and goes to ST_IGNORE on a not-acknowledge.

Top module: `i2c_regfile_target`

## Requirements
- R1: A falling data line while the clock line is high is a start. From any state, including after a non-matching address, it begins a fresh address reception with the bit count cleared.
- R2: A rising data line while the clock line is high is a stop. It returns the block to idle and releases the data line. A partly received byte is discarded and not stored.
- R3: The address byte is taken most significant bit first: seven address bits, then a direction bit where 0 means the controller writes and 1 means the controller reads.
- R4: Only an address equal to `DEV_ADDR` (default 7'h42) is acknowledged. Any other address leaves the data line released, for all later bytes, until the next start.
- R5: After the address byte and after each written byte, the block pulls the data line low for the whole ninth clock.
- R6: The first byte written after the address loads the register pointer from its low log2(`REG_COUNT`) bits. That byte is not stored.
- R7: Each later written byte is stored in the register at the pointer, and the pointer then increases by one.
- R8: Read bytes are sent most significant bit first from the register at the pointer, and the pointer increases by one after each byte. A read with no pointer write continues from the current pointer.
- R9: The pointer keeps its value across a repeated start, so a read that follows begins at the register just selected.
- R10: The pointer wraps from `REG_COUNT`-1 to 0, both when writing and when reading.
- R11: A not-acknowledge from the controller after a read byte ends transmission. The data line stays released (bytes clocked afterwards read as 8'hFF), and the pointer stops advancing until the next start or stop.
- R12: The block changes its data-line drive only while the clock line is low, except in the cycle after a start or stop.
- R13: After reset the data line is released and all registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus (wired-AND result) |
| sda_drive_low | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
Two things happen in the same system-clock cycle at the falling clock that closes a data byte written into the last register: the store into register `REG_COUNT`-1 and the wrap of the pointer to zero. The test points the pointer at register 7 and writes two bytes back to back. If the store used the already-wrapped pointer, or the wrap lost the store, the first byte would land in register 0 or vanish. Reading both registers back through a repeated start, in order 7 then 0, judges the pair.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WRITE,
        ST_WRITE_ACK,
        ST_READ,
        ST_READ_ACK,
        ST_IGNORE
    } tgt_state_e;

    // Bus events decoded from the synchronized lines
    typedef struct packed {
        logic scl_high;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync
    import i2ct_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);

    localparam int LINES = 2;
    localparam int SCL_IDX = 1;
    localparam int SDA_IDX = 0;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] prv;

    assign raw = {scl_in, sda_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe <= '1;
            end else begin
                pipe <= {pipe[STAGES-1:0], raw[g]};
            end
        end
        assign cur[g] = pipe[STAGES-1];
        assign prv[g] = pipe[STAGES];
    end

    always_comb begin
        evt          = '0;
        evt.scl_high = cur[SCL_IDX];
        evt.scl_rise = cur[SCL_IDX] & ~prv[SCL_IDX];
        evt.scl_fall = ~cur[SCL_IDX] & prv[SCL_IDX];
        evt.start    = cur[SCL_IDX] & prv[SCL_IDX] & prv[SDA_IDX] & ~cur[SDA_IDX];
        evt.stop     = cur[SCL_IDX] & prv[SCL_IDX] & ~prv[SDA_IDX] & cur[SDA_IDX];
        evt.sda      = cur[SDA_IDX];
    end

endmodule

// File: rtl/i2ct_regfile.sv
module i2ct_regfile #(
    parameter int REG_COUNT = 8,
    parameter int DATA_W    = 8,
    localparam int PTR_W    = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] cells [REG_COUNT];

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cells[g] <= '0;
            end else if (wr_en && (wr_idx == PTR_W'(g))) begin
                cells[g] <= wr_data;
            end
        end
    end

    assign rd_data = cells[rd_idx];

endmodule

// File: rtl/i2ct_ctrl.sv
module i2ct_ctrl
    import i2ct_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h42,
    parameter int         REG_COUNT = 8,
    localparam int        PTR_W     = $clog2(REG_COUNT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  bus_evt_t             evt,
    input  logic [BYTE_BITS-1:0] rd_data,
    output logic                 wr_en,
    output logic [PTR_W-1:0]     wr_idx,
    output logic [BYTE_BITS-1:0] wr_data,
    output logic [PTR_W-1:0]     rd_idx,
    output logic                 sda_drive,
    output tgt_state_e           state_o,
    output logic [PTR_W-1:0]     ptr_o
);

    localparam int CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);
    localparam logic [PTR_W-1:0] PTR_TOP  = PTR_W'(REG_COUNT - 1);

    tgt_state_e           state_q, state_d;
    logic [CNT_W-1:0]     bitcnt_q;
    logic [BYTE_BITS-1:0] shreg_q;
    logic [BYTE_BITS-1:0] txbyte_q;
    logic [PTR_W-1:0]     ptr_q;
    logic                 rw_q;
    logic                 first_q;
    logic                 ack_q;

    logic                 byte_done;
    logic                 addr_hit;
    logic                 byte_end;
    logic [PTR_W-1:0]     ptr_next;

    assign byte_done = (bitcnt_q == LAST_BIT);
    assign byte_end  = evt.scl_fall && byte_done;
    assign addr_hit  = (shreg_q[BYTE_BITS-1:1] == DEV_ADDR);
    assign ptr_next  = (ptr_q == PTR_TOP) ? '0 : ptr_q + 1'b1;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (evt.stop) begin
            state_d = ST_IDLE;
        end else if (evt.start) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: state_d = state_q;
                ST_ADDR:      if (byte_end) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (evt.scl_fall) state_d = rw_q ? ST_READ : ST_WRITE;
                ST_WRITE:     if (byte_end) state_d = ST_WRITE_ACK;
                ST_WRITE_ACK: if (evt.scl_fall) state_d = ST_WRITE;
                ST_READ:      if (byte_end) state_d = ST_READ_ACK;
                ST_READ_ACK:  if (evt.scl_fall) state_d = ack_q ? ST_READ : ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Shift, count and byte registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            shreg_q  <= '0;
            txbyte_q <= '1;
            rw_q     <= 1'b0;
            first_q  <= 1'b0;
            ack_q    <= 1'b0;
        end else if (evt.start || evt.stop) begin
            bitcnt_q <= '0;
            txbyte_q <= '1;
            first_q  <= 1'b0;
            ack_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ADDR, ST_WRITE: begin
                    if (evt.scl_rise) begin
                        shreg_q  <= {shreg_q[BYTE_BITS-2:0], evt.sda};
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end
                    if (byte_end) begin
                        bitcnt_q <= '0;
                        if (state_q == ST_ADDR) begin
                            rw_q <= shreg_q[0];
                        end else begin
                            first_q <= 1'b0;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (evt.scl_fall) begin
                        bitcnt_q <= '0;
                        first_q  <= ~rw_q;
                        txbyte_q <= rd_data;
                    end
                end
                ST_READ: begin
                    if (evt.scl_rise) begin
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end
                    if (evt.scl_fall) begin
                        if (byte_done) begin
                            bitcnt_q <= '0;
                            txbyte_q <= '1;
                        end else begin
                            txbyte_q <= {txbyte_q[BYTE_BITS-2:0], 1'b1};
                        end
                    end
                end
                ST_READ_ACK: begin
                    if (evt.scl_rise) begin
                        ack_q <= ~evt.sda;
                    end
                    if (evt.scl_fall && ack_q) begin
                        txbyte_q <= rd_data;
                    end
                end
                ST_IDLE, ST_WRITE_ACK, ST_IGNORE: begin
                    bitcnt_q <= bitcnt_q;
                end
                default: bitcnt_q <= '0;
            endcase
        end
    end

    // Register pointer: loaded by the first written byte, stepped per data byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (!evt.start && !evt.stop && byte_end) begin
            if (state_q == ST_WRITE) begin
                ptr_q <= first_q ? shreg_q[PTR_W-1:0] : ptr_next;
            end else if (state_q == ST_READ) begin
                ptr_q <= ptr_next;
            end
        end
    end

    // Outputs
    always_comb begin
        sda_drive = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK, ST_WRITE_ACK: sda_drive = 1'b1;
            ST_READ:                   sda_drive = ~txbyte_q[BYTE_BITS-1];
            default:                   sda_drive = 1'b0;
        endcase
        wr_en   = (state_q == ST_WRITE) && byte_end && !first_q && !evt.start && !evt.stop;
        wr_idx  = ptr_q;
        wr_data = shreg_q;
        rd_idx  = ptr_q;
        state_o = state_q;
        ptr_o   = ptr_q;
    end

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
    import i2ct_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h42,
    parameter int         REG_COUNT   = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_drive_low
);

    localparam int PTR_W = $clog2(REG_COUNT);

    bus_evt_t             evt;
    logic                 wr_en;
    logic [PTR_W-1:0]     wr_idx;
    logic [BYTE_BITS-1:0] wr_data;
    logic [PTR_W-1:0]     rd_idx;
    logic [BYTE_BITS-1:0] rd_data;
    tgt_state_e           ctrl_state;
    logic [PTR_W-1:0]     ctrl_ptr;

    i2ct_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    i2ct_regfile #(
        .REG_COUNT (REG_COUNT),
        .DATA_W    (BYTE_BITS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    i2ct_ctrl #(
        .DEV_ADDR  (DEV_ADDR),
        .REG_COUNT (REG_COUNT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .sda_drive (sda_drive_low),
        .state_o   (ctrl_state),
        .ptr_o     (ctrl_ptr)
    );

endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker
    import i2ct_pkg::*;
#(
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input bus_evt_t         evt,
    input tgt_state_e       state,
    input logic             sda_drive,
    input logic [PTR_W-1:0] ptr
);

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.start && !evt.stop) |=> (state == ST_ADDR)); // R1

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        evt.stop |=> (state == ST_IDLE && !sda_drive)); // R2

    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_drive); // R4

    AST_ADDR_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK || state == ST_WRITE_ACK) |-> sda_drive); // R5

    AST_PTR_ONLY_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr) |-> ($past(state) == ST_WRITE || $past(state) == ST_READ)); // R7

    AST_PTR_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ptr) && $past(state) == ST_READ) |-> (ptr == PTR_W'($past(ptr) + 1'b1))); // R10

    AST_NO_READ_AFTER_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_READ_ACK && state == ST_IGNORE) |-> !sda_drive); // R11

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.scl_high && $past(evt.scl_high) && !$past(evt.start) && !$past(evt.stop))
        |-> $stable(sda_drive)); // R12

endmodule

bind i2c_regfile_target i2ct_checker #(
    .PTR_W (PTR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .state     (ctrl_state),
    .sda_drive (sda_drive_low),
    .ptr       (ctrl_ptr)
);

// File: tb/i2c_regfile_target_tb.sv
module i2c_regfile_target_tb;

    localparam int         Q      = 10;
    localparam logic [6:0] OWN    = 7'h42;
    localparam logic [6:0] OTHER  = 7'h43;
    localparam logic [7:0] OWN_W  = {OWN, 1'b0};
    localparam logic [7:0] OWN_R  = {OWN, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_drive_low;
    logic sda_bus;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] obs_q[$];

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_drive_low;

    i2c_regfile_target u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_m),
        .sda_in        (sda_bus),
        .sda_drive_low (sda_drive_low)
    );

    function automatic void check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endfunction

    function automatic void summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    endfunction

    // Bus controller model
    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
        qwait();
    endtask

    task automatic m_bit_w(input logic b);
        sda_m = b; qwait();
        scl_m = 1'b1; qwait();
        qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic m_bit_r(output logic b);
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        b = sda_bus; qwait();
        scl_m = 1'b0; qwait();
    endtask

    // Driver: write a byte and judge the acknowledge bit (0 = ack)
    task automatic wr(string req, input logic [7:0] d, input logic exp_nack);
        logic a;
        for (int i = 7; i >= 0; i--) m_bit_w(d[i]);
        m_bit_r(a);
        check(req, {7'b0, a}, {7'b0, exp_nack});
    endtask

    // Driver: push expectation, clock in a byte, hand it to the monitor
    task automatic rd(string req, input logic [7:0] exp, input logic nack);
        logic [7:0] d;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        for (int i = 7; i >= 0; i--) m_bit_r(d[i]);
        m_bit_w(nack);
        obs_q.push_back(d);
    endtask

    // Monitor: compares observed read bytes against the scoreboard
    initial begin
        forever begin
            wait (obs_q.size() != 0);
            check(tag_q.pop_front(), obs_q.pop_front(), exp_q.pop_front());
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] exp_ff;
        exp_ff = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R13 released after reset", {7'b0, sda_drive_low}, 8'h00);

        // R3 R4 R5 R6 R7: pointer load then two stored bytes
        m_start();
        wr("R4 own address acked", OWN_W, 1'b0);
        wr("R6 pointer byte acked", 8'h02, 1'b0);
        wr("R5 data byte acked", 8'hAA, 1'b0);
        wr("R7 second data byte acked", 8'h55, 1'b0);
        m_stop();

        // R9 R8 R3: pointer write, repeated start, read back
        m_start();
        wr("R3 write direction", OWN_W, 1'b0);
        wr("R6 pointer 2", 8'h02, 1'b0);
        m_start();
        wr("R3 read direction acked", OWN_R, 1'b0);
        rd("R9 read starts at chosen register", 8'hAA, 1'b0);
        rd("R8 next register", 8'h55, 1'b1);
        m_stop();

        // R10: last register store and wrap in the same byte end
        m_start();
        wr("R10 addr", OWN_W, 1'b0);
        wr("R10 pointer 7", 8'h07, 1'b0);
        wr("R10 store to 7", 8'h11, 1'b0);
        wr("R10 store to 0 after wrap", 8'h22, 1'b0);
        m_start();
        wr("R10 addr", OWN_W, 1'b0);
        wr("R10 pointer 7 again", 8'h07, 1'b0);
        m_start();
        wr("R10 read addr", OWN_R, 1'b0);
        rd("R10 reg 7", 8'h11, 1'b0);
        rd("R10 reg 0 after read wrap", 8'h22, 1'b1);
        m_stop();

        // R8: read with no pointer write resumes at pointer 1
        m_start();
        wr("R8 read addr", OWN_R, 1'b0);
        rd("R8 resume reg 1", 8'h00, 1'b0);
        rd("R8 resume reg 2", 8'hAA, 1'b1);
        m_stop();

        // R11: NACK ends transmission, pointer halts
        m_start();
        wr("R11 addr", OWN_W, 1'b0);
        wr("R11 pointer 3", 8'h03, 1'b0);
        m_start();
        wr("R11 read addr", OWN_R, 1'b0);
        rd("R11 reg 3", 8'h55, 1'b1);
        rd("R11 released after NACK", exp_ff, 1'b1);
        m_stop();
        m_start();
        wr("R11 read addr", OWN_R, 1'b0);
        rd("R11 pointer stopped at 4", 8'h00, 1'b1);
        m_stop();

        // R4: foreign address, write and read directions
        m_start();
        wr("R4 foreign address not acked", {OTHER, 1'b0}, 1'b1);
        wr("R4 ignored byte not acked", 8'h00, 1'b1);
        wr("R4 ignored byte not acked", 8'h77, 1'b1);
        m_stop();
        m_start();
        wr("R4 foreign read not acked", {OTHER, 1'b1}, 1'b1);
        rd("R4 foreign read released", exp_ff, 1'b1);
        m_stop();
        m_start();
        wr("R4 addr", OWN_W, 1'b0);
        wr("R4 pointer 0", 8'h00, 1'b0);
        m_start();
        wr("R4 read addr", OWN_R, 1'b0);
        rd("R4 reg 0 untouched", 8'h22, 1'b0);
        rd("R4 reg 1 untouched", 8'h00, 1'b1);
        m_stop();

        // R1: repeated start after a foreign address
        m_start();
        wr("R1 foreign first", {OTHER, 1'b0}, 1'b1);
        m_start();
        wr("R1 own after repeated start", OWN_W, 1'b0);
        wr("R1 pointer 5", 8'h05, 1'b0);
        wr("R1 store C3", 8'hC3, 1'b0);
        m_stop();

        // R2: stop in the middle of a byte
        m_start();
        wr("R2 addr", OWN_W, 1'b0);
        wr("R2 pointer 6", 8'h06, 1'b0);
        m_bit_w(1'b1); m_bit_w(1'b0); m_bit_w(1'b1); m_bit_w(1'b1);
        m_stop();
        check("R2 released after stop", {7'b0, sda_drive_low}, 8'h00);
        m_start();
        wr("R2 addr", OWN_W, 1'b0);
        wr("R2 pointer 5", 8'h05, 1'b0);
        m_start();
        wr("R2 read addr", OWN_R, 1'b0);
        rd("R1 reg 5 stored", 8'hC3, 1'b0);
        rd("R2 partial byte not stored", 8'h00, 1'b0);
        rd("R2 reg 7 intact", 8'h11, 1'b1);
        m_stop();

        wait (obs_q.size() == 0);
        repeat (5) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule